// File: doc/BRIEF.md
# Interleaved Host-Address Window Decoder

This block owns a single address window that a memory device exposes to its host. Software programs the window with a 64-bit start address, a 64-bit length and a control word. Each of these 64-bit values is split across a pair of 32-bit registers. The control word carries the interleave granularity, the interleave way count and a commit handshake. Register writes arrive on a simple 32-bit write port. A combinational read port lets software see the stored values.

A host physical address presented on the translation port is checked against the window. On a hit, the block strips the way-selector bits out of the window offset to form a device physical address. It then compares that address with the size of the backing store. The outcome is registered once and returned on the next cycle.

The two access directions handle a miss differently. A read that misses, or that lands past the end of the backing store, is flagged as an error. A write in the same situation is dropped without an error, so the requester still sees success.

Top module: `hdm_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads back zero and res_valid, res_ok, res_err and res_drop are 0.
- R2: A write with reg_wr_bytes equal to 4 is stored whole at its offset: window start low 0x10, start high 0x14, length low 0x18, length high 0x1C, control 0x20. The stored value reads back on reg_rd_data from the cycle after the write.
- R3: Two kinds of write change no register: a write whose reg_wr_bytes is not 4, and a write to an offset outside the five listed ones. Reading an unlisted offset returns zero.
- R4: A control write with bit 9 (commit request) set is first stored. In the same cycle, bit 9 and bit 11 (error) are cleared and bit 10 (committed) is set, so the read-back value is the written data with bit 9 = 0, bit 10 = 1 and bit 11 = 0.
- R5: A control write with bit 9 clear is stored exactly as written, including bits 10 and 11.
- R6: The window start is {start high, start low} and the window length is {length high, length low}. An address below the start misses. Otherwise the offset is the address minus the start, and an offset at or above the length misses.
- R7: The granularity field is control bits 3:0 (G) and the way field is control bits 7:4 (W). On a hit, res_dpa keeps offset bits below 8+G unchanged and holds offset bits from 8+G+W upward, shifted down by W. res_dpa is 0 whenever res_ok is 0.
- R8: A request with tr_valid high at a clock edge produces res_valid high after exactly that edge. res_valid is low after an edge with tr_valid low.
- R9: A read (tr_write = 0) that misses, or whose device address is at or above MEM_BYTES, gives res_err = 1 and res_ok = 0.
- R10: A write (tr_write = 1) that misses, or whose device address is at or above MEM_BYTES, gives res_drop = 1, res_err = 0 and res_ok = 0.
- R11: A hit whose device address is below MEM_BYTES gives res_ok = 1 with res_err = 0 and res_drop = 0, for either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_bytes | input | 3 | Access width in bytes; only 4 is accepted |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| tr_valid | input | 1 | Translation request valid |
| tr_write | input | 1 | Request direction: 1 write, 0 read |
| tr_addr | input | 64 | Host physical address |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_ok | output | 1 | Hit inside the backing store |
| res_err | output | 1 | Read failed |
| res_drop | output | 1 | Write silently discarded |
| res_dpa | output | 64 | Device physical address, zero unless res_ok |

## Verification
The assertions assume three things about the inputs. The granularity and way fields stay small enough that 8+G+W is below 64. reg_wr_bytes is meaningful only while reg_wr_en is high. The window registers are not rewritten in the same cycle as a translation request that depends on them. The stimulus keeps to these limits as follows. It programs only G values 0 to 6 and W values 0 to 4. It completes each register write and waits a full cycle before translating. It sweeps every G/W pair across the window edges (start-1, start, start+length-1, start+length) plus one interior address, in both directions. The window sits above the 32-bit boundary, so both halves of each 64-bit value take part in every comparison.

// File: rtl/hdm_pkg.sv
// Package: shared register layout for the interleaved window decoder.
// Assumes 32-bit registers laid out back to back from a fixed first offset.
package hdm_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2 * REG_W;
    localparam int REG_AW     = 8;
    localparam int NREG       = 5;
    localparam logic [REG_AW-1:0] FIRST_OFF = 8'h10;

    // register indices, each at FIRST_OFF + 4*index
    localparam int IDX_BASE_LO = 0;
    localparam int IDX_BASE_HI = 1;
    localparam int IDX_SIZE_LO = 2;
    localparam int IDX_SIZE_HI = 3;
    localparam int IDX_CTRL    = 4;

    // control word fields
    localparam int GRAN_LSB      = 0;
    localparam int WAYS_LSB      = 4;
    localparam int FIELD_W       = 4;
    localparam int BIT_COMMIT    = 9;
    localparam int BIT_COMMITTED = 10;
    localparam int BIT_ERROR     = 11;

    localparam int MIN_GRAN_SHIFT = 8;

    // byte offset of register index i
    function automatic logic [REG_AW-1:0] reg_off(input int i);
        return FIRST_OFF + REG_AW'(4 * i);
    endfunction
endpackage

// File: rtl/hdm_regfile.sv
// Module: hdm_regfile
// Holds the window start, length and control registers, applies whole-word
// writes and runs the commit handshake on the control register.
// Assumes: only 4-byte writes are legal; narrower ones are discarded.
module hdm_regfile
    import hdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [2:0]        wr_bytes,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] win_size,
    output logic [FIELD_W-1:0] gran,
    output logic [FIELD_W-1:0] ways
);
    logic [REG_W-1:0] regs_q [NREG];
    logic             word_ok;
    logic [NREG-1:0]  sel;

    // Purpose: qualify the access width once for every register
    assign word_ok = wr_en && (wr_bytes == 3'd4);

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            // Purpose: decode whether this register is the write target
            assign sel[gi] = word_ok && (wr_addr == reg_off(gi));

            if (gi == IDX_CTRL) begin : g_ctrl
                // Purpose: store control writes, then apply commit side effects
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs_q[gi] <= '0;
                    end else if (sel[gi]) begin
                        if (wr_data[BIT_COMMIT]) begin
                            regs_q[gi]                <= wr_data;
                            regs_q[gi][BIT_COMMIT]    <= 1'b0;
                            regs_q[gi][BIT_ERROR]     <= 1'b0;
                            regs_q[gi][BIT_COMMITTED] <= 1'b1;
                        end else begin
                            regs_q[gi] <= wr_data;
                        end
                    end
                end

                AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
                    (sel[gi] && wr_data[BIT_COMMIT]) |=>
                    (rd_cmp_ctrl[BIT_COMMITTED] && !rd_cmp_ctrl[BIT_COMMIT]
                     && !rd_cmp_ctrl[BIT_ERROR])); // R4
            end else begin : g_plain
                // Purpose: store a plain address register word
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs_q[gi] <= '0;
                    end else if (sel[gi]) begin
                        regs_q[gi] <= wr_data;
                    end
                end
            end

            AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_bytes != 3'd4) |=> $stable(regs_q[gi])); // R3
        end
    endgenerate

    logic [REG_W-1:0] rd_cmp_ctrl;
    // Purpose: expose the control word for the guard on the commit handshake
    assign rd_cmp_ctrl = regs_q[IDX_CTRL];

    // Purpose: combinational read mux, zero for unlisted offsets
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == reg_off(i)) rd_data = regs_q[i];
        end
    end

    // Purpose: assemble the 64-bit window values and the interleave fields
    assign win_base = {regs_q[IDX_BASE_HI], regs_q[IDX_BASE_LO]};
    assign win_size = {regs_q[IDX_SIZE_HI], regs_q[IDX_SIZE_LO]};
    assign gran     = regs_q[IDX_CTRL][GRAN_LSB +: FIELD_W];
    assign ways     = regs_q[IDX_CTRL][WAYS_LSB +: FIELD_W];

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < FIRST_OFF) |-> (rd_data == '0)); // R3
endmodule

// File: rtl/hdm_xlate.sv
// Module: hdm_xlate
// Combinational window check and interleave removal.
// Assumes 8 + gran + ways stays below ADDR_W.
module hdm_xlate
    import hdm_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  win_base,
    input  logic [ADDR_W-1:0]  win_size,
    input  logic [FIELD_W-1:0] gran,
    input  logic [FIELD_W-1:0] ways,
    output logic               hit,
    output logic [ADDR_W-1:0]  offset,
    output logic [ADDR_W-1:0]  dpa
);
    localparam int SH_W = 7;

    logic [SH_W-1:0]   keep_sh;
    logic [SH_W-1:0]   drop_sh;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] upper;

    // Purpose: window membership and offset
    always_comb begin
        offset = addr - win_base;
        hit    = (addr >= win_base) && (offset < win_size);
    end

    // Purpose: keep the low granule bits, fold the upper bits over the way selector
    always_comb begin
        keep_sh   = SH_W'(MIN_GRAN_SHIFT) + SH_W'(gran);
        drop_sh   = keep_sh + SH_W'(ways);
        keep_mask = (ADDR_W'(1) << keep_sh) - ADDR_W'(1);
        upper     = (offset >> drop_sh) << keep_sh;
        dpa       = hit ? ((offset & keep_mask) | upper) : '0;
    end
endmodule

// File: rtl/hdm_decoder.sv
// Module: hdm_decoder (top)
// One programmable host-address window with power-of-two interleave removal,
// a backing-size check and a single registered result stage.
// Assumes the window registers are quiet while a dependent request is issued.
module hdm_decoder
    import hdm_pkg::*;
#(
    parameter logic [63:0] MEM_BYTES = 64'h0000_0000_0100_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wr_addr,
    input  logic [2:0]  reg_wr_bytes,
    input  logic [31:0] reg_wr_data,
    input  logic [7:0]  reg_rd_addr,
    output logic [31:0] reg_rd_data,
    input  logic        tr_valid,
    input  logic        tr_write,
    input  logic [63:0] tr_addr,
    output logic        res_valid,
    output logic        res_ok,
    output logic        res_err,
    output logic        res_drop,
    output logic [63:0] res_dpa
);
    logic [ADDR_W-1:0]  win_base, win_size, offset_c, dpa_c;
    logic [FIELD_W-1:0] gran, ways;
    logic               hit_c, ok_c;

    hdm_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_bytes (reg_wr_bytes),
        .wr_data  (reg_wr_data),
        .rd_addr  (reg_rd_addr),
        .rd_data  (reg_rd_data),
        .win_base (win_base),
        .win_size (win_size),
        .gran     (gran),
        .ways     (ways)
    );

    hdm_xlate u_xlate (
        .addr     (tr_addr),
        .win_base (win_base),
        .win_size (win_size),
        .gran     (gran),
        .ways     (ways),
        .hit      (hit_c),
        .offset   (offset_c),
        .dpa      (dpa_c)
    );

    // Purpose: a hit counts only if it lands inside the backing store
    assign ok_c = hit_c && (dpa_c < MEM_BYTES);

    // Purpose: register the outcome, split by direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_ok    <= 1'b0;
            res_err   <= 1'b0;
            res_drop  <= 1'b0;
            res_dpa   <= '0;
        end else begin
            res_valid <= tr_valid;
            res_ok    <= tr_valid && ok_c;
            res_err   <= tr_valid && !ok_c && !tr_write;
            res_drop  <= tr_valid && !ok_c && tr_write;
            res_dpa   <= (tr_valid && ok_c) ? dpa_c : '0;
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid |=> res_valid); // R8
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !tr_valid |=> !(res_valid || res_ok || res_err || res_drop)); // R8
    AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_ok, res_err, res_drop}) == 1); // R9
    AST_WRITE_NEVER_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_write) |=> !res_err); // R10
    AST_DPA_WITHIN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && hit_c) |-> (dpa_c <= offset_c)); // R7
    AST_LOW_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && hit_c) |-> (dpa_c[7:0] == offset_c[7:0])); // R7
    AST_BELOW_START_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_addr < win_base) |=> !res_ok); // R6
endmodule

// File: tb/hdm_decoder_tb.sv
module hdm_decoder_tb;
    localparam logic [63:0] MEM  = 64'h0000_0000_0100_0000;
    localparam logic [63:0] BASE = 64'h0000_0001_4000_0000;
    localparam logic [63:0] SIZE = 64'h0000_0000_0200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [2:0]  reg_wr_bytes = '0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        tr_valid = 1'b0;
    logic        tr_write = 1'b0;
    logic [63:0] tr_addr = '0;
    logic        res_valid, res_ok, res_err, res_drop;
    logic [63:0] res_dpa;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    hdm_decoder #(.MEM_BYTES(MEM)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_bytes(reg_wr_bytes), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .tr_valid(tr_valid), .tr_write(tr_write), .tr_addr(tr_addr),
        .res_valid(res_valid), .res_ok(res_ok), .res_err(res_err),
        .res_drop(res_drop), .res_dpa(res_dpa)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] nb);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d; reg_wr_bytes = nb;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_rd_addr = a;
        #1;
        check(req, {32'd0, reg_rd_data}, {32'd0, exp});
    endtask

    // independent model of the interleave removal
    function automatic logic [63:0] model_dpa(input logic [63:0] off, input int g, input int w);
        logic [63:0] lo_m, hi_m;
        lo_m = (64'd1 << (8 + g)) - 1;
        hi_m = ~((64'd1 << (8 + g + w)) - 1);
        return (off & lo_m) | ((off & hi_m) >> w);
    endfunction

    task automatic xlate_check(input string tag, input logic [63:0] a, input logic wrdir,
                               input int g, input int w);
        logic        hit, ok;
        logic [63:0] dpa;
        hit = (a >= BASE) && ((a - BASE) < SIZE);
        dpa = hit ? model_dpa(a - BASE, g, w) : 64'd0;
        ok  = hit && (dpa < MEM);
        @(negedge clk);
        tr_valid = 1'b1; tr_write = wrdir; tr_addr = a;
        @(negedge clk);
        tr_valid = 1'b0;
        check({tag, " R8 valid"}, {63'd0, res_valid}, 64'd1);
        check({tag, " R11 ok"}, {63'd0, res_ok}, {63'd0, ok});
        check({tag, wrdir ? " R10 err" : " R9 err"}, {63'd0, res_err}, {63'd0, !ok && !wrdir});
        check({tag, " R10 drop"}, {63'd0, res_drop}, {63'd0, !ok && wrdir});
        check({tag, " R7 R6 dpa"}, res_dpa, ok ? dpa : 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) rd_check("R1 reg zero", 8'(8'h10 + 4 * i), 32'd0);
        check("R1 res_valid", {63'd0, res_valid}, 64'd0);
        check("R1 res flags", {61'd0, res_ok, res_err, res_drop}, 64'd0);
    endtask

    task automatic t_regs();
        wr(8'h10, BASE[31:0], 3'd4);
        wr(8'h14, BASE[63:32], 3'd4);
        wr(8'h18, SIZE[31:0], 3'd4);
        wr(8'h1C, SIZE[63:32], 3'd4);
        rd_check("R2 start lo", 8'h10, BASE[31:0]);
        rd_check("R2 start hi", 8'h14, BASE[63:32]);
        rd_check("R2 len lo", 8'h18, SIZE[31:0]);
        rd_check("R2 len hi", 8'h1C, SIZE[63:32]);
    endtask

    task automatic t_ignored();
        wr(8'h10, 32'hDEAD_BEEF, 3'd2);
        rd_check("R3 narrow write ignored", 8'h10, BASE[31:0]);
        wr(8'h20, 32'h0000_0633, 3'd1);
        rd_check("R3 narrow ctrl ignored", 8'h20, 32'd0);
        wr(8'h24, 32'h1234_5678, 3'd4);
        rd_check("R3 unmapped reads zero", 8'h24, 32'd0);
        rd_check("R3 neighbour untouched", 8'h1C, SIZE[63:32]);
        rd_check("R3 ctrl untouched", 8'h20, 32'd0);
    endtask

    task automatic t_commit();
        wr(8'h20, 32'h0000_0834, 3'd4);
        rd_check("R5 verbatim ctrl", 8'h20, 32'h0000_0834);
        wr(8'h20, 32'h0000_0E35, 3'd4);
        rd_check("R4 commit all flags", 8'h20, 32'h0000_0435);
        wr(8'h20, 32'h0000_0200, 3'd4);
        rd_check("R4 commit bare", 8'h20, 32'h0000_0400);
        wr(8'h20, 32'h0000_0000, 3'd4);
        rd_check("R5 clear ctrl", 8'h20, 32'd0);
    endtask

    task automatic t_sweep();
        for (int g = 0; g <= 6; g++) begin
            for (int w = 0; w <= 4; w++) begin
                wr(8'h20, 32'h200 | 32'(w << 4) | 32'(g), 3'd4);
                for (int d = 0; d < 2; d++) begin
                    xlate_check("edge start-1", BASE - 1, d[0], g, w);
                    xlate_check("edge start", BASE, d[0], g, w);
                    xlate_check("interior", BASE + 64'h0123_4567, d[0], g, w);
                    xlate_check("edge end-1", BASE + SIZE - 1, d[0], g, w);
                    xlate_check("edge end", BASE + SIZE, d[0], g, w);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_ignored();
        t_commit();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule